// File: doc/BRIEF.md
# Register-Mapped Watchdog Countdown Timer

This block is a watchdog timer on a 32-bit system-bus register port. Firmware sets a reload count, turns the watchdog on through a control bit, and must keep writing a fixed restart key before the count runs out. While the watchdog is running, the count drops by one on every cycle in which the rate tick is high. When the count reaches zero the block sends a single-cycle reset request. The counter then stays at zero until firmware restarts it with the key or turns the enable off and on again.

Registers are read and written one whole word at a time. Reads are combinational from the address. Writes take effect on the clock edge. Offsets that are not in the map read as zero, and writes to them are ignored. This includes byte addresses that are not word aligned. The timeout-status, timeout-clear and reset-width words are reserved: they read as zero and ignore writes.

Top module: `wdog_regtimer`

## Requirements
- R1: After reset, the count word (offset 0x00) and the reload word (offset 0x04) both read 0x03EF1480. The control word (offset 0x0C) reads 0 and resetReq is low.
- R2: The reload word at 0x04 can be read and written as a full 32-bit value.
- R3: A write to the restart word (0x08) copies the reload value into the count only when write data bits 15:0 equal 0x4755. Bits 31:16 are ignored. Any other low half leaves the count unchanged.
- R4: In the control word at 0x0C, bit 0 is the enable and the other bits read 0. Writing 1 while disabled loads the count from the reload value and starts counting.
- R5: Writing the enable bit with the value it already holds changes nothing. Writing 0 while enabled freezes the count, and ticks then have no effect.
- R6: While running, each cycle with tick high lowers the count by one. The count word always shows the live count.
- R7: When a tick takes the count from 1 to 0, resetReq is high for exactly one cycle. The count then stays at 0 through further ticks and no further pulse is sent.
- R8: With a reload value of 0, the first tick after the watchdog is armed causes expiry.
- R9: A keyed restart while disabled loads the count word, but ticks still do not change it.
- R10: A keyed restart while enabled takes priority over a tick in the same cycle. A keyed restart or a re-enable after expiry resumes counting from the reload value.
- R11: The restart word reads 0. Writes to the count word are ignored.
- R12: Offsets 0x10, 0x14 and 0x18, unmapped offsets, and addresses that are not word aligned all read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Byte address of the word being accessed |
| wrEn | input | 1 | Write strobe for the current word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr (combinational) |
| tick | input | 1 | Count-rate enable; one decrement per high cycle while running |
| resetReq | output | 1 | One-cycle reset request sent on expiry |

## Verification
The hardest states to reach are a keyed restart that lands in the same cycle as a tick, and the halted state after expiry. The bench drives the restart write and the tick on the same edge. It then reads the count, which must equal the reload value and not one less. To reach the halted state, the bench sweeps small reload values, including 0. It counts the ticks until the pulse, keeps ticking after expiry, and then checks that both a keyed restart and a disable/enable cycle bring the countdown back.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Strobes from the control section to the counter datapath
  typedef struct packed {
    logic loadCount;
    logic decCount;
    logic writeReload;
  } wdog_stb_t;

  localparam int OFF_COUNT   = 'h00;
  localparam int OFF_RELOAD  = 'h04;
  localparam int OFF_RESTART = 'h08;
  localparam int OFF_CTRL    = 'h0C;

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int KEY_W       = 16,
  parameter logic [KEY_W-1:0] RESTART_KEY = 16'h4755
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [KEY_W-1:0]  wrKey,
  input  logic              tick,
  input  logic              countLeOne,
  input  logic [DATA_W-1:0] countVal,
  input  logic [DATA_W-1:0] reloadVal,
  output wdog_stb_t         stb,
  output logic              running,
  output logic              resetReq,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [ADDR_W-1:0] A_COUNT   = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_RELOAD  = ADDR_W'(OFF_RELOAD);
  localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(OFF_RESTART);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFF_CTRL);

  logic enabled, halted;
  logic selReload, selRestart, selCtrl;
  logic keyOk, restartHit, enRise, enFall, expire;

  assign selReload  = (addr == A_RELOAD);
  assign selRestart = (addr == A_RESTART);
  assign selCtrl    = (addr == A_CTRL);

  assign keyOk      = (wrKey == RESTART_KEY);
  assign restartHit = wrEn && selRestart && keyOk;
  assign enRise     = wrEn && selCtrl && wrKey[0] && !enabled;
  assign enFall     = wrEn && selCtrl && !wrKey[0] && enabled;

  assign running = enabled && !halted;

  always_comb begin
    stb.loadCount   = restartHit || enRise;
    stb.decCount    = running && tick && !stb.loadCount && !enFall;
    stb.writeReload = wrEn && selReload;
  end

  assign expire = stb.decCount && countLeOne;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enabled  <= 1'b0;
      halted   <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= expire;
      if (enRise)      enabled <= 1'b1;
      else if (enFall) enabled <= 1'b0;
      if (stb.loadCount) halted <= 1'b0;
      else if (expire)   halted <= 1'b1;
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == A_COUNT)  rdData = countVal;
    else if (selReload)   rdData = reloadVal;
    else if (selCtrl)     rdData = DATA_W'(enabled);
  end

endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RESET_COUNT = 32'h03EF1480
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdog_stb_t         stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] countQ,
  output logic [DATA_W-1:0] reloadQ,
  output logic              countLeOne
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  assign countLeOne = (countQ <= ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= RESET_COUNT;
    end else if (stb.writeReload) begin
      reloadQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= RESET_COUNT;
    end else if (stb.loadCount) begin
      countQ <= reloadQ;
    end else if (stb.decCount && (countQ != '0)) begin
      countQ <= countQ - ONE;
    end
  end

endmodule

// File: rtl/wdog_regtimer.sv
module wdog_regtimer
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int KEY_W  = 16,
  parameter logic [KEY_W-1:0]  RESTART_KEY = 16'h4755,
  parameter logic [DATA_W-1:0] RESET_COUNT = 32'h03EF1480
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              tick,
  output logic              resetReq
);

  wdog_stb_t         stb;
  logic [DATA_W-1:0] countQ, reloadQ;
  logic              countLeOne, running;

  wdog_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W), .RESTART_KEY(RESTART_KEY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
    .wrKey(wrData[KEY_W-1:0]), .tick(tick), .countLeOne(countLeOne),
    .countVal(countQ), .reloadVal(reloadQ), .stb(stb), .running(running),
    .resetReq(resetReq), .rdData(rdData)
  );

  wdog_datapath #(
    .DATA_W(DATA_W), .RESET_COUNT(RESET_COUNT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .countQ(countQ), .reloadQ(reloadQ), .countLeOne(countLeOne)
  );

endmodule

// File: rtl/wdog_regtimer_chk.sv
module wdog_regtimer_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              tick,
  input logic              resetReq,
  input logic [DATA_W-1:0] count,
  input logic              running
);

  // R7: the request is a single-cycle pulse
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  // R7: a request is only ever seen with the count at zero
  a_r7_zero_at_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (count == '0));

  // R6: a plain tick while running lowers the count by one
  a_r6_decrement: assert property (@(posedge clk) disable iff (!rstN)
    (running && tick && !wrEn && (count > DATA_W'(1))) |=> (count == $past(count) - DATA_W'(1)));

  // R5 / R9: with no write and not running, the count holds
  a_r5_hold_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !wrEn) |=> $stable(count));

  // R3: a restart with a wrong key and no tick leaves the count alone
  a_r3_bad_key: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == ADDR_W'('h08)) && (wrData[15:0] != 16'h4755) && !(running && tick))
      |=> $stable(count));

endmodule

bind wdog_regtimer wdog_regtimer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
  .tick(tick), .resetReq(resetReq), .count(countQ), .running(running)
);

// File: tb/wdog_regtimer_tb.sv
module wdog_regtimer_tb;

  localparam logic [7:0] O_CNT = 8'h00, O_RLD = 8'h04, O_RST = 8'h08, O_CTL = 8'h0C;
  localparam logic [31:0] KEY = 32'h0000_4755;
  localparam logic [31:0] POR = 32'h03EF1480;

  logic        clk = 0, rstN = 0, wrEn = 0, tick = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wrData = 0, rdData;
  logic        resetReq;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wdog_regtimer u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .tick(tick), .resetReq(resetReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; wrEn = 0; #1 d = rdData;
  endtask

  task automatic tk;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int pulses;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset values
    rd(O_CNT, v); chk("R1 count", v, POR);
    rd(O_RLD, v); chk("R1 reload", v, POR);
    rd(O_CTL, v); chk("R1 ctrl", v, 0);
    chk("R1 resetReq", resetReq, 0);

    // R2 reload read/write
    wr(O_RLD, 32'hA5A5_1234); rd(O_RLD, v); chk("R2 reload", v, 32'hA5A5_1234);

    // R11 restart reads 0, count writes ignored
    rd(O_RST, v); chk("R11 restart read", v, 0);
    wr(O_CNT, 32'h1111_1111); rd(O_CNT, v); chk("R11 count write ignored", v, POR);

    // R3 key check (disabled)
    wr(O_RLD, 32'd50);
    wr(O_RST, 32'h0000_4756); rd(O_CNT, v); chk("R3 bad key", v, POR);
    wr(O_RST, 32'hFFFF_4755); rd(O_CNT, v); chk("R3 key upper ignored", v, 50);

    // R9 restart while disabled: no counting
    wr(O_RLD, 32'd20); wr(O_RST, KEY);
    tk(); tk(); rd(O_CNT, v); chk("R9 no count when disabled", v, 20);

    // R12 reserved, unmapped, misaligned
    for (int a = 'h10; a <= 'h18; a += 4) begin
      wr(8'(a), 32'hFFFF_FFFF); rd(8'(a), v); chk("R12 reserved reads 0", v, 0);
    end
    wr(8'h40, 32'h1234); rd(8'h40, v); chk("R12 unmapped", v, 0);
    wr(8'h05, 32'h55); rd(O_RLD, v); chk("R12 misaligned write ignored", v, 20);
    rd(8'h05, v); chk("R12 misaligned read", v, 0);
    wr(8'h0D, 32'h1); rd(O_CTL, v); chk("R12 misaligned ctrl", v, 0);

    // R4 enable edge, R6 decrement, R5 same-value and disable
    wr(O_RLD, 32'd10); wr(O_CTL, 32'h1);
    rd(O_CTL, v); chk("R4 ctrl reads enable", v, 1);
    rd(O_CNT, v); chk("R4 load on enable", v, 10);
    for (int k = 1; k <= 3; k++) begin
      tk(); rd(O_CNT, v); chk("R6 live decrement", v, 10 - k);
    end
    wr(O_CTL, 32'h1); rd(O_CNT, v); chk("R5 same enable no reload", v, 7);
    tk(); rd(O_CNT, v); chk("R5 still counting", v, 6);
    wr(O_CTL, 32'h0);
    tk(); tk(); tk(); rd(O_CNT, v); chk("R5 disable freezes", v, 6);
    wr(O_CTL, 32'h0); rd(O_CTL, v); chk("R5 disable again", v, 0);
    wr(O_CTL, 32'h1); rd(O_CNT, v); chk("R4 re-enable reloads", v, 10);

    // R3 while enabled: bad key no reload
    tk(); wr(O_RST, 32'h0001_0000); rd(O_CNT, v); chk("R3 bad key running", v, 9);

    // R10 restart beats tick in same cycle
    @(negedge clk); addr = O_RST; wrData = KEY; wrEn = 1; tick = 1;
    @(negedge clk); wrEn = 0; tick = 0;
    rd(O_CNT, v); chk("R10 restart over tick", v, 10);
    wr(O_CTL, 0);

    // R7/R8 sweep over reload values
    for (int r = 0; r <= 6; r++) begin
      int need;
      need = (r == 0) ? 1 : r;
      pulses = 0;
      wr(O_RLD, 32'(r)); wr(O_CTL, 0); wr(O_CTL, 1);
      chk(r == 0 ? "R8 no pulse on arm" : "R7 no pulse on arm", resetReq, 0);
      for (int k = 1; k <= need + 3; k++) begin
        tk();
        if (resetReq) pulses++;
        chk(r == 0 ? "R8 pulse timing" : "R7 pulse timing", resetReq, (k == need) ? 1 : 0);
        @(negedge clk);
        chk("R7 pulse one cycle", resetReq, 0);
      end
      chk("R7 exactly one pulse", pulses, 1);
      rd(O_CNT, v); chk("R7 halted at zero", v, 0);
    end

    // R10 resume after expiry via restart and via re-enable
    wr(O_RLD, 32'd3); wr(O_CTL, 0); wr(O_CTL, 1);
    tk(); tk(); tk(); tk();
    rd(O_CNT, v); chk("R7 stays zero", v, 0);
    wr(O_RST, KEY); rd(O_CNT, v); chk("R10 restart after expiry", v, 3);
    tk(); rd(O_CNT, v); chk("R10 counting resumed", v, 2);
    tk(); tk(); chk("R10 second expiry pulse", resetReq, 1);
    wr(O_CTL, 0); wr(O_CTL, 1);
    tk(); rd(O_CNT, v); chk("R10 re-enable resumes", v, 2);

    finish_run();
  end

endmodule